// File: doc/BRIEF.md
# Indirect Memory Port Address Generator

This block sits beside a small signal processor and turns its accesses to a handful of indirect memory port registers into addresses for an external data memory and an external program memory. Each port keeps two 32-bit descriptors, one for reads and one for writes. A descriptor's low half is a 16-bit mode word and its high half is a word address. Software programs a descriptor through a shared 32-bit control register. It loads the register with two consecutive 16-bit accesses and then makes one access to the target port, which arms that port's descriptor for the direction of the access.

Once a descriptor is armed, every access to that port in that direction performs a memory transfer. The mode word picks the behaviour: a plain access, a fixed post-step of +1, +32, −16 or −128, a cell pattern step, a program memory fetch, or a nibble-masked overwrite. After each transfer the descriptor address is updated, and the control register is reloaded from that descriptor so software can read back where the pointer now stands.

Requests enter on a valid/ready channel and responses leave on a second valid/ready channel. Only one request is in flight at a time. `req_ready` is high only when no request is executing and no response is waiting. A response stays on `rsp_valid`/`rsp_rdata`/`rsp_err` unchanged until `rsp_ready` accepts it, so a stalled consumer stalls the requester. Both memories are read combinationally: the read data for the address driven in a cycle must be present in that same cycle.

Top module: `xmem_agu`

## Requirements
- R1: The control register is accessed in two steps. With the have-address state clear, a control access targets bits 31:16 and sets have-address. With it set, the access targets bits 15:0, clears have-address and sets the pending state. A control read returns the selected half, and a control write replaces only that half.
- R2: While pending is set, the next access to a valid port makes no memory access. It copies the control value into that port's read descriptor (on a read) or write descriptor (on a write), clears pending, and responds with data 0 and no error.
- R3: A write with mode 0x0018 stores the data at the descriptor address and leaves the address unchanged. Mode 0x0818 stores the data and then adds 1 to the address.
- R4: Write mode 0x4018 stores the data and then adds 1 to the address when it is even, or 31 when it is odd.
- R5: Write modes 0x0418 and 0x4418 replace only the 4-bit nibbles of the stored word whose incoming nibble is nonzero. Mode 0x4418 also applies the step of R4.
- R6: Read modes return the data word at the descriptor address and then step the address: 0x0018 by 0, 0x0818 by +1, 0x3018 by +32, 0xa818 by −16 and 0xb818 by −128. All address arithmetic wraps modulo 2^16.
- R7: A read mode whose bits 15:4 equal 0x080 returns the program memory word at address {mode[3:0], address} and then adds 1 to the address.
- R8: After a port transfer, the control register holds that port's descriptor for that direction, including the address update, and have-address is clear.
- R9: A transfer with an unrecognised mode, or any access to a port number of 5 or above, responds with data 0 and `rsp_err` high. It does not write memory and leaves every descriptor unchanged.
- R10: Reset clears all descriptors and the control register to zero. Each of the five ports keeps independent read and write descriptors.
- R11: A request is accepted only while `req_ready` is high, and `req_ready` stays low until the response is taken. A response with `rsp_ready` low holds its valid, data and error flag unchanged. `dmem_we` is a single-cycle pulse that only follows an accepted port request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_ctrl | input | 1 | 1 = control register access, 0 = port access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 3 | Port number for port accesses |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data (0 for writes, arming and errors) |
| rsp_err | output | 1 | Unrecognised mode or bad port |
| dmem_addr | output | 16 | Data memory word address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 16 | Data memory write word |
| dmem_rdata | input | 16 | Data memory word at dmem_addr, same cycle |
| pmem_addr | output | 20 | Program memory word address |
| pmem_rdata | input | 16 | Program memory word at pmem_addr, same cycle |

## Verification
The assertions assume that the requester counts a request as taken only at a cycle where valid and ready are both high. They also assume that both memories answer combinationally, so the word seen on `dmem_rdata` during a transfer matches `dmem_addr` and the nibble merge reads the current contents. The bench drives every request on the falling edge, holds it until `req_ready` is seen, and models both memories as combinational look-ups. Only the back-pressure sequence withholds `rsp_ready`, so the stall behaviour is exercised on purpose and nowhere else.

// File: rtl/xagu_pkg.sv
package xagu_pkg;
  localparam int unsigned WORD_W = 16;

  localparam logic [15:0] MD_PLAIN    = 16'h0018;
  localparam logic [15:0] MD_INC1     = 16'h0818;
  localparam logic [15:0] MD_CELL     = 16'h4018;
  localparam logic [15:0] MD_NIB      = 16'h0418;
  localparam logic [15:0] MD_NIB_CELL = 16'h4418;
  localparam logic [15:0] MD_INC32    = 16'h3018;
  localparam logic [15:0] MD_DEC16    = 16'ha818;
  localparam logic [15:0] MD_DEC128   = 16'hb818;
  localparam logic [11:0] MD_PROG_TAG = 12'h080;

  typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_RESP} phase_t;

  typedef struct packed {
    logic              ok;
    logic              prog;
    logic              merge;
    logic [WORD_W-1:0] next_addr;
  } step_t;
endpackage

// File: rtl/xagu_mode_dec.sv
module xagu_mode_dec
  import xagu_pkg::*;
(
  input  logic              is_write,
  input  logic [15:0]       mode,
  input  logic [WORD_W-1:0] addr,
  output step_t             step
);
  logic [WORD_W-1:0] cell_next;

  always_comb begin
    cell_next = addr[0] ? addr + WORD_W'(31) : addr + WORD_W'(1);
    step      = '0;
    step.next_addr = addr;
    if (is_write) begin
      case (mode)
        MD_PLAIN:    step.ok = 1'b1;
        MD_INC1:     begin step.ok = 1'b1; step.next_addr = addr + WORD_W'(1); end
        MD_CELL:     begin step.ok = 1'b1; step.next_addr = cell_next; end
        MD_NIB:      begin step.ok = 1'b1; step.merge = 1'b1; end
        MD_NIB_CELL: begin step.ok = 1'b1; step.merge = 1'b1; step.next_addr = cell_next; end
        default:     step.ok = 1'b0;
      endcase
    end else if (mode[15:4] == MD_PROG_TAG) begin
      step.ok        = 1'b1;
      step.prog      = 1'b1;
      step.next_addr = addr + WORD_W'(1);
    end else begin
      case (mode)
        MD_PLAIN:  step.ok = 1'b1;
        MD_INC1:   begin step.ok = 1'b1; step.next_addr = addr + WORD_W'(1); end
        MD_INC32:  begin step.ok = 1'b1; step.next_addr = addr + WORD_W'(32); end
        MD_DEC16:  begin step.ok = 1'b1; step.next_addr = addr - WORD_W'(16); end
        MD_DEC128: begin step.ok = 1'b1; step.next_addr = addr - WORD_W'(128); end
        default:   step.ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xagu_nib_merge.sv
module xagu_nib_merge #(
  parameter int unsigned W     = 16,
  parameter int unsigned NIB_W = 4
) (
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] new_word,
  output logic [W-1:0] merged
);
  localparam int unsigned N_NIB = W / NIB_W;

  for (genvar g = 0; g < N_NIB; g++) begin : g_nib
    logic [NIB_W-1:0] nin;
    assign nin = new_word[g*NIB_W +: NIB_W];
    assign merged[g*NIB_W +: NIB_W] = (nin != '0) ? nin : old_word[g*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/xagu_arm.sv
module xagu_arm
  import xagu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic                acc_wr,
  input  logic [WORD_W-1:0]   acc_data,
  input  logic                arm_clr,
  input  logic                reload,
  input  logic [2*WORD_W-1:0] reload_val,
  output logic [2*WORD_W-1:0] ctrl_q,
  output logic                pending_q,
  output logic [WORD_W-1:0]   half_rd
);
  logic have_q;

  assign half_rd = have_q ? ctrl_q[WORD_W-1:0] : ctrl_q[2*WORD_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      have_q    <= 1'b0;
      pending_q <= 1'b0;
    end else if (acc) begin
      if (!have_q) begin
        if (acc_wr) ctrl_q[2*WORD_W-1:WORD_W] <= acc_data;
        have_q <= 1'b1;
      end else begin
        if (acc_wr) ctrl_q[WORD_W-1:0] <= acc_data;
        have_q    <= 1'b0;
        pending_q <= 1'b1;
      end
    end else if (arm_clr) begin
      pending_q <= 1'b0;
    end else if (reload) begin
      ctrl_q <= reload_val;
      have_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xagu_desc_bank.sv
module xagu_desc_bank #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned DESC_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PORT_W-1:0] port,
  input  logic              dir_wr,
  input  logic [DESC_W-1:0] wval,
  output logic [DESC_W-1:0] rval
);
  logic [DESC_W-1:0] desc_q [NUM_PORTS][2];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar d = 0; d < 2; d++) begin : g_dir
      always_ff @(posedge clk) begin
        if (!rst_n) desc_q[p][d] <= '0;
        else if (we && port == PORT_W'(p) && dir_wr == d[0]) desc_q[p][d] <= wval;
      end
    end
  end

  always_comb begin
    rval = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port == PORT_W'(p)) rval = desc_q[p][dir_wr];
    end
  end
endmodule

// File: rtl/xmem_agu.sv
module xmem_agu
  import xagu_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned NIB_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_ctrl,
  input  logic                     req_write,
  input  logic [2:0]               req_port,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  output logic [WORD_W-1:0]        dmem_addr,
  output logic                     dmem_we,
  output logic [WORD_W-1:0]        dmem_wdata,
  input  logic [WORD_W-1:0]        dmem_rdata,
  output logic [WORD_W+PAGE_W-1:0] pmem_addr,
  input  logic [WORD_W-1:0]        pmem_rdata
);
  localparam int unsigned PORT_W = 3;
  localparam int unsigned DESC_W = 2 * WORD_W;

  phase_t              phase_q;
  logic                op_ctrl_q, op_wr_q;
  logic [PORT_W-1:0]   op_port_q;
  logic [WORD_W-1:0]   op_data_q;
  logic [WORD_W-1:0]   rsp_data_q;
  logic                rsp_err_q;

  logic                exec, port_ok, is_arm, is_xfer, do_ok;
  logic [DESC_W-1:0]   ctrl_val, desc_cur, desc_new, desc_wval;
  logic                pending;
  logic [WORD_W-1:0]   ctrl_half, merged, rdata_d;
  logic                err_d;
  step_t               step;

  assign exec    = (phase_q == PH_EXEC);
  assign port_ok = (op_port_q < PORT_W'(NUM_PORTS));
  assign is_arm  = exec && !op_ctrl_q && port_ok && pending;
  assign is_xfer = exec && !op_ctrl_q && port_ok && !pending;
  assign do_ok   = is_xfer && step.ok;

  xagu_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (exec && op_ctrl_q),
    .acc_wr     (op_wr_q),
    .acc_data   (op_data_q),
    .arm_clr    (is_arm),
    .reload     (is_xfer),
    .reload_val (do_ok ? desc_new : desc_cur),
    .ctrl_q     (ctrl_val),
    .pending_q  (pending),
    .half_rd    (ctrl_half)
  );

  xagu_desc_bank #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .DESC_W    (DESC_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (is_arm || do_ok),
    .port   (op_port_q),
    .dir_wr (op_wr_q),
    .wval   (desc_wval),
    .rval   (desc_cur)
  );

  xagu_mode_dec u_dec (
    .is_write (op_wr_q),
    .mode     (desc_cur[WORD_W-1:0]),
    .addr     (desc_cur[DESC_W-1:WORD_W]),
    .step     (step)
  );

  xagu_nib_merge #(
    .W     (WORD_W),
    .NIB_W (NIB_W)
  ) u_merge (
    .old_word (dmem_rdata),
    .new_word (op_data_q),
    .merged   (merged)
  );

  assign desc_new  = {step.next_addr, desc_cur[WORD_W-1:0]};
  assign desc_wval = is_arm ? ctrl_val : desc_new;

  assign dmem_addr  = desc_cur[DESC_W-1:WORD_W];
  assign dmem_we    = do_ok && op_wr_q;
  assign dmem_wdata = step.merge ? merged : op_data_q;
  assign pmem_addr  = {desc_cur[PAGE_W-1:0], desc_cur[DESC_W-1:WORD_W]};

  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    if (op_ctrl_q) begin
      rdata_d = op_wr_q ? '0 : ctrl_half;
    end else if (!port_ok) begin
      err_d = 1'b1;
    end else if (!pending) begin
      if (!step.ok)     err_d   = 1'b1;
      else if (!op_wr_q) rdata_d = step.prog ? pmem_rdata : dmem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      op_ctrl_q  <= 1'b0;
      op_wr_q    <= 1'b0;
      op_port_q  <= '0;
      op_data_q  <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_valid) begin
          op_ctrl_q <= req_ctrl;
          op_wr_q   <= req_write;
          op_port_q <= req_port;
          op_data_q <= req_wdata;
          phase_q   <= PH_EXEC;
        end
        PH_EXEC: begin
          rsp_data_q <= rdata_d;
          rsp_err_q  <= err_d;
          phase_q    <= PH_RESP;
        end
        PH_RESP: if (rsp_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_err   = rsp_err_q;
endmodule

// File: rtl/xmem_agu_chk.sv
module xmem_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_ctrl,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        rsp_err,
  input logic        dmem_we
);
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 16'h0000));

  p_we_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> $past(req_valid && req_ready && !req_ctrl));

  p_we_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);
endmodule

bind xmem_agu xmem_agu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ctrl  (req_ctrl),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .dmem_we   (dmem_we)
);

// File: tb/xmem_agu_bench.sv
module xmem_agu_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ctrl = 1'b0, req_write = 1'b0;
  logic [2:0]  req_port = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, dmem_we;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata, dmem_addr, dmem_wdata, dmem_rdata, pmem_rdata;
  logic [19:0] pmem_addr;

  logic [15:0] mem [1024];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dmem_rdata = mem[dmem_addr[9:0]];
  assign pmem_rdata = pmem_addr[15:0] ^ {pmem_addr[19:16], 12'h5A5};
  always @(posedge clk) if (dmem_we) mem[dmem_addr[9:0]] <= dmem_wdata;

  xmem_agu u_xmem_agu (.*);

  function automatic logic [15:0] prog_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A5};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit c, input bit w, input logic [2:0] p, input logic [15:0] d,
                        output logic [15:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_ctrl = c; req_write = w; req_port = p; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic arm(input logic [2:0] p, input bit w, input logic [15:0] mode, input logic [15:0] addr);
    logic [15:0] rd; logic er;
    access(1, 1, 0, addr, rd, er);
    access(1, 1, 0, mode, rd, er);
    access(0, w, p, 16'hDEAD, rd, er);
  endtask

  task automatic peek(input logic [2:0] p, input bit w, output logic [15:0] hi, output logic [15:0] lo);
    logic [15:0] rd; logic er;
    access(1, 0, 0, 0, hi, er);
    access(1, 0, 0, 0, lo, er);
    access(0, w, p, 16'h0, rd, er);   // re-arm same descriptor, clears pending
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd, hi, lo, exp;
    logic er;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset req_ready", {31'd0, req_ready}, 1);
    check("R11 reset rsp_valid", {31'd0, rsp_valid}, 0);

    // R10: reset descriptors zero -> mode 0 unrecognised
    access(0, 0, 0, 0, rd, er);
    check("R10 reset desc read err", {15'd0, er, rd}, {15'd0, 1'b1, 16'h0});
    access(1, 0, 0, 0, hi, er);
    access(1, 0, 0, 0, lo, er);
    check("R10 reset ctrl zero", {hi, lo}, 0);
    access(0, 0, 0, 0, rd, er);   // arm port0 read with zero
    check("R2 arm response", {15'd0, er, rd}, 0);

    // R1: two-step control halves
    access(1, 1, 0, 16'hAAAA, rd, er);
    access(1, 1, 0, 16'h5555, rd, er);
    access(1, 0, 0, 0, hi, er);
    access(1, 0, 0, 0, lo, er);
    check("R1 ctrl halves", {hi, lo}, 32'hAAAA5555);
    access(0, 0, 4, 0, rd, er);   // arms port4 read with bad mode
    access(0, 0, 4, 0, rd, er);
    check("R9 bad read mode", {15'd0, er, rd}, {15'd0, 1'b1, 16'h0});

    // R3/R6/R10 sweep over ports with +1 stride
    for (int p = 0; p < 5; p++) begin
      logic [15:0] base;
      base = 16'(p * 64 + 64);
      arm(3'(p), 1, 16'h0818, base);
      arm(3'(p), 0, 16'h0818, base);
      for (int i = 0; i < 4; i++) access(0, 1, 3'(p), 16'(16'hC000 + p * 16 + i), rd, er);
      for (int i = 0; i < 4; i++)
        check("R3 inc1 write mem", {16'd0, mem[base + 16'(i)]}, {16'd0, 16'(16'hC000 + p * 16 + i)});
      peek(3'(p), 1, hi, lo);
      check("R8 reload after write", {hi, lo}, {base + 16'd4, 16'h0818});
      for (int i = 0; i < 4; i++) begin
        access(0, 0, 3'(p), 0, rd, er);
        check("R6 R10 inc1 read", {15'd0, er, rd}, {16'd0, 16'(16'hC000 + p * 16 + i)});
      end
    end

    // R3 plain write: address unchanged
    arm(1, 1, 16'h0018, 16'd500);
    access(0, 1, 1, 16'h1111, rd, er);
    access(0, 1, 1, 16'h2222, rd, er);
    check("R3 plain write", {16'd0, mem[500]}, 16'h2222);
    peek(1, 1, hi, lo);
    check("R3 plain addr held", {hi, lo}, {16'd500, 16'h0018});

    // R2: arming writes nothing
    mem[510] = 16'h0BAD;
    arm(1, 1, 16'h0018, 16'd510);
    check("R2 arm no write", {16'd0, mem[510]}, 16'h0BAD);

    // R4 cell step from even address
    arm(2, 1, 16'h4018, 16'd600);
    for (int i = 0; i < 4; i++) access(0, 1, 2, 16'(16'h4000 + i), rd, er);
    check("R4 cell 600", {16'd0, mem[600]}, 16'h4000);
    check("R4 cell 601", {16'd0, mem[601]}, 16'h4001);
    check("R4 cell 632", {16'd0, mem[632]}, 16'h4002);
    check("R4 cell 633", {16'd0, mem[633]}, 16'h4003);
    peek(2, 1, hi, lo);
    check("R4 R8 cell next", {hi, lo}, {16'd664, 16'h4018});

    // R5 nibble overwrite
    mem[700] = 16'h1234;
    arm(3, 1, 16'h0418, 16'd700);
    access(0, 1, 3, 16'h0A0B, rd, er);
    check("R5 nibble merge", {16'd0, mem[700]}, 16'h1A3B);
    mem[701] = 16'hFFFF;
    arm(3, 1, 16'h4418, 16'd701);
    access(0, 1, 3, 16'h5000, rd, er);
    check("R5 nibble cell merge", {16'd0, mem[701]}, 16'h5FFF);
    peek(3, 1, hi, lo);
    check("R5 nibble cell step", {hi, lo}, {16'd732, 16'h4418});

    // R6 read strides
    arm(0, 0, 16'h3018, 16'd100);
    for (int i = 0; i < 3; i++) begin
      access(0, 0, 0, 0, rd, er);
      check("R6 inc32 read", {16'd0, rd}, {16'd0, mem[100 + 32 * i]});
    end
    arm(0, 0, 16'ha818, 16'd900);
    for (int i = 0; i < 3; i++) begin
      access(0, 0, 0, 0, rd, er);
      check("R6 dec16 read", {16'd0, rd}, {16'd0, mem[900 - 16 * i]});
    end
    arm(0, 0, 16'hb818, 16'd900);
    for (int i = 0; i < 3; i++) begin
      access(0, 0, 0, 0, rd, er);
      check("R6 dec128 read", {16'd0, rd}, {16'd0, mem[900 - 128 * i]});
    end
    arm(0, 0, 16'ha818, 16'd8);
    access(0, 0, 0, 0, rd, er);
    peek(0, 0, hi, lo);
    check("R6 wrap addr", {hi, lo}, {16'hFFF8, 16'ha818});
    access(0, 0, 0, 0, rd, er);
    check("R6 wrap read", {16'd0, rd}, {16'd0, mem[10'h3F8]});

    // R7 program memory fetch with address wrap
    arm(4, 0, 16'h0805, 16'hFFFF);
    access(0, 0, 4, 0, rd, er);
    check("R7 prog read", {15'd0, er, rd}, {16'd0, prog_word(20'h5FFFF)});
    access(0, 0, 4, 0, rd, er);
    check("R7 prog read wrap", {15'd0, er, rd}, {16'd0, prog_word(20'h50000)});
    peek(4, 0, hi, lo);
    check("R7 R8 prog step", {hi, lo}, {16'd1, 16'h0805});

    // R9 bad write mode and bad port
    mem[50] = 16'h7777;
    arm(2, 1, 16'h1234, 16'd50);
    access(0, 1, 2, 16'h1111, rd, er);
    check("R9 bad write err", {15'd0, er, rd}, {15'd0, 1'b1, 16'h0});
    check("R9 bad write no mem", {16'd0, mem[50]}, 16'h7777);
    peek(2, 1, hi, lo);
    check("R9 desc unchanged", {hi, lo}, {16'd50, 16'h1234});
    access(0, 0, 6, 0, rd, er);
    check("R9 bad port", {15'd0, er, rd}, {15'd0, 1'b1, 16'h0});
    arm(2, 0, 16'h0018, 16'd20);
    access(0, 1, 7, 16'h9999, rd, er);
    access(0, 0, 2, 0, rd, er);
    check("R9 bad port no effect", {15'd0, er, rd}, {16'd0, mem[20]});

    // R11 back-pressure
    arm(1, 0, 16'h0018, 16'd10);
    exp = mem[10];
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ctrl = 1'b0; req_write = 1'b0; req_port = 3'd1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 held response", {14'd0, req_ready, rsp_valid, rsp_rdata}, {14'd0, 1'b0, 1'b1, exp});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 release", {30'd0, req_ready, rsp_valid}, {30'd0, 1'b1, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule